// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block drains a circular list of transmit buffer descriptors held in system memory. A kick input starts a walk at the current descriptor pointer. Each descriptor is two 32-bit words. The first word holds a 16-bit byte count and 16 bits of flags, and the second holds the address of the data buffer.

For each descriptor whose ready flag is set, the block copies the buffer into an on-chip frame store one byte at a time. When the descriptor also carries the last-in-frame flag, the assembled frame is played out on a byte stream with valid/ready handshaking. Every consumed descriptor is written back with its ready flag cleared. The pointer then moves to the next descriptor, or back to the ring base when the wrap flag is set.

Event pulses report each finished buffer, each finished frame and each frame that overflowed the store. Software restarts the ring by dropping the enable input, which returns the pointer to the ring base.

Top module: `txr_ring_walker`

## Requirements
- R1: Out of reset, mem_req, tx_valid, ev_buf, ev_frame and ev_babble are all low.
- R2: Descriptor word 0 (at the pointer) carries the length in bits 15:0 and flags in bits 31:16. Within the flags, ready is bit 15, wrap is bit 13 and last is bit 11. Word 1 (at pointer+4) is the buffer address. Memory words are little-endian: the byte at address a is lane a[1:0] of the word at a with a[1:0] cleared.
- R3: A walk stops at the first descriptor whose ready flag is clear. The pointer stays there, and the next kick resumes from it.
- R4: After a descriptor is processed, the pointer advances by 8, or is loaded from ring_base when the wrap flag is set.
- R5: Buffer bytes are appended in address order. On a descriptor with last set, the whole frame is sent on tx_data, with tx_last on the final byte only.
- R6: If the frame length plus a buffer's length exceeds MAX_FRAME, only the bytes up to MAX_FRAME are copied, and ev_babble pulses together with that buffer's ev_buf.
- R7: ev_buf pulses once per processed descriptor. ev_frame pulses once per emitted frame, and never in the same cycle as ev_buf.
- R8: Write-back stores word 0 with the ready flag cleared and the length and the other flags unchanged.
- R9: A kick while eth_en is low is neither acted on nor remembered. While eth_en is low, no memory request and no stream beat is issued.
- R10: While eth_en is low, the pointer is reloaded from ring_base, so the next walk starts at ring_base.
- R11: A stream beat offered while tx_ready is low is held with unchanged data and tx_last.
- R12: A memory request stays asserted with the same address and direction until mem_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eth_en | input | 1 | Engine enable; low aborts and reloads the pointer |
| kick | input | 1 | Start a ring walk |
| ring_base | input | AW | Address of the first descriptor in the ring |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Word-aligned request address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completed this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| tx_data | output | 8 | Frame byte |
| tx_valid | output | 1 | Frame byte valid |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | Sink accepts the byte |
| ev_buf | output | 1 | One-cycle pulse per processed buffer |
| ev_frame | output | 1 | One-cycle pulse per emitted frame |
| ev_babble | output | 1 | One-cycle pulse when a buffer was truncated |

## Verification
The assertions assume that mem_ack is raised only while mem_req is high. They also assume that ring_base and every descriptor address are word-aligned, and that eth_en is dropped only while the engine is idle. The bench memory model acks only pending requests, adding a rotating zero to two cycles of latency. The bench places all descriptors on 8-byte boundaries and toggles eth_en only after the engine has been quiet for several cycles. tx_ready follows a fixed two-of-three pattern, so held beats occur throughout every frame.

// File: rtl/txr_pkg.sv
package txr_pkg;
  localparam int FLG_READY = 15;
  localparam int FLG_WRAP  = 13;
  localparam int FLG_LAST  = 11;

  typedef enum logic [2:0] {
    S_IDLE,
    S_HDR,
    S_BPTR,
    S_COPY,
    S_BDONE,
    S_SEND,
    S_WBACK
  } txr_state_e;
endpackage

// File: rtl/txr_desc_ptr.sv
module txr_desc_ptr #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reload,
  input  logic          advance,
  input  logic          wrap,
  input  logic [AW-1:0] base,
  output logic [AW-1:0] ptr
);
  logic [AW-1:0] ptr_q, ptr_d;
  logic          ptr_en;

  always_comb begin
    ptr_en = reload | advance;
    if (reload || wrap) ptr_d = base;
    else                ptr_d = ptr_q + AW'(8);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;
endmodule

// File: rtl/txr_frame_buf.sv
module txr_frame_buf #(
  parameter int DEPTH = 2032,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [IW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];
endmodule

// File: rtl/txr_ring_walker.sv
module txr_ring_walker
  import txr_pkg::*;
#(
  parameter int AW        = 32,
  parameter int MAX_FRAME = 2032
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          eth_en,
  input  logic          kick,
  input  logic [AW-1:0] ring_base,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic [7:0]    tx_data,
  output logic          tx_valid,
  output logic          tx_last,
  input  logic          tx_ready,
  output logic          ev_buf,
  output logic          ev_frame,
  output logic          ev_babble
);
  localparam int LW = $clog2(MAX_FRAME + 1);
  localparam int IW = $clog2(MAX_FRAME);
  localparam logic [16:0] MAXV = 17'(MAX_FRAME);

  txr_state_e    state_q, state_d;
  logic          pend_q, pend_d;
  logic [15:0]   len_q, len_d, flags_q, flags_d, cnt_q, cnt_d;
  logic [AW-1:0] bptr_q, bptr_d;
  logic [LW-1:0] flen_q, flen_d, oidx_q, oidx_d;
  logic          trunc_q, trunc_d;
  logic          evb_q, evb_d, evf_q, evf_d, eva_q, eva_d;

  logic [AW-1:0] ptr;
  logic          advance, fb_we;
  logic [7:0]    lane_byte, fb_rdata;
  logic [16:0]   sum_w, room_w;
  logic          kick_acc;

  txr_desc_ptr #(.AW(AW)) ptr_i (
    .clk(clk), .rst_n(rst_n), .reload(!eth_en), .advance(advance),
    .wrap(flags_q[FLG_WRAP]), .base(ring_base), .ptr(ptr)
  );

  txr_frame_buf #(.DEPTH(MAX_FRAME)) fb_i (
    .clk(clk), .we(fb_we), .waddr(flen_q[IW-1:0]), .wdata(lane_byte),
    .raddr(oidx_q[IW-1:0]), .rdata(fb_rdata)
  );

  always_comb begin
    lane_byte = 8'(mem_rdata >> {bptr_q[1:0], 3'b000});
    sum_w     = 17'(flen_q) + 17'(len_q);
    room_w    = MAXV - 17'(flen_q);
    kick_acc  = kick & eth_en;
  end

  always_comb begin
    state_d = state_q;  pend_d  = pend_q;   len_d  = len_q;
    flags_d = flags_q;  cnt_d   = cnt_q;    bptr_d = bptr_q;
    flen_d  = flen_q;   oidx_d  = oidx_q;   trunc_d = trunc_q;
    evb_d = 1'b0;  evf_d = 1'b0;  eva_d = 1'b0;
    mem_req = 1'b0;  mem_we = 1'b0;  mem_addr = ptr;
    mem_wdata = {flags_q & ~(16'd1 << FLG_READY), len_q};
    tx_valid = 1'b0;  tx_last = 1'b0;  tx_data = fb_rdata;
    advance = 1'b0;  fb_we = 1'b0;

    unique case (state_q)
      S_IDLE: begin
        if (pend_q || kick_acc) begin
          state_d = S_HDR;
          pend_d  = 1'b0;
        end
      end
      S_HDR: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          len_d   = mem_rdata[15:0];
          flags_d = mem_rdata[31:16];
          state_d = mem_rdata[16+FLG_READY] ? S_BPTR : S_IDLE;
        end
      end
      S_BPTR: begin
        mem_req  = 1'b1;
        mem_addr = ptr + AW'(4);
        if (mem_ack) begin
          bptr_d  = mem_rdata[AW-1:0];
          trunc_d = (sum_w > MAXV);
          cnt_d   = trunc_d ? room_w[15:0] : len_q;
          state_d = (cnt_d == 16'd0) ? S_BDONE : S_COPY;
        end
      end
      S_COPY: begin
        mem_req  = 1'b1;
        mem_addr = {bptr_q[AW-1:2], 2'b00};
        if (mem_ack) begin
          fb_we  = 1'b1;
          flen_d = flen_q + LW'(1);
          bptr_d = bptr_q + AW'(1);
          cnt_d  = cnt_q - 16'd1;
          if (cnt_q == 16'd1) state_d = S_BDONE;
        end
      end
      S_BDONE: begin
        evb_d  = 1'b1;
        eva_d  = trunc_q;
        oidx_d = '0;
        state_d = flags_q[FLG_LAST] ? S_SEND : S_WBACK;
      end
      S_SEND: begin
        if (flen_q == '0) begin
          evf_d   = 1'b1;
          state_d = S_WBACK;
        end else begin
          tx_valid = 1'b1;
          tx_last  = (oidx_q == flen_q - LW'(1));
          if (tx_ready) begin
            oidx_d = oidx_q + LW'(1);
            if (tx_last) begin
              evf_d   = 1'b1;
              flen_d  = '0;
              oidx_d  = '0;
              state_d = S_WBACK;
            end
          end
        end
      end
      S_WBACK: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
        if (mem_ack) begin
          advance = 1'b1;
          state_d = S_HDR;
        end
      end
      default: state_d = S_IDLE;
    endcase

    if (state_q != S_IDLE && kick_acc) pend_d = 1'b1;

    if (!eth_en) begin
      state_d = S_IDLE;  pend_d = 1'b0;
      flen_d  = '0;      oidx_d = '0;
      evb_d = 1'b0;  evf_d = 1'b0;  eva_d = 1'b0;
      advance = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;  pend_q  <= 1'b0;
      len_q   <= '0;      flags_q <= '0;   cnt_q  <= '0;
      bptr_q  <= '0;      flen_q  <= '0;   oidx_q <= '0;
      trunc_q <= 1'b0;
      evb_q <= 1'b0;  evf_q <= 1'b0;  eva_q <= 1'b0;
    end else begin
      state_q <= state_d;  pend_q  <= pend_d;
      len_q   <= len_d;    flags_q <= flags_d;  cnt_q  <= cnt_d;
      bptr_q  <= bptr_d;   flen_q  <= flen_d;   oidx_q <= oidx_d;
      trunc_q <= trunc_d;
      evb_q <= evb_d;  evf_q <= evf_d;  eva_q <= eva_d;
    end
  end

  assign ev_buf    = evb_q;
  assign ev_frame  = evf_q;
  assign ev_babble = eva_q;
endmodule

// File: rtl/txr_ring_walker_chk.sv
module txr_ring_walker_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          eth_en,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_wdata,
  input logic          mem_ack,
  input logic [7:0]    tx_data,
  input logic          tx_valid,
  input logic          tx_last,
  input logic          tx_ready,
  input logic          ev_buf,
  input logic          ev_frame,
  input logic          ev_babble
);
  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack && eth_en |=>
      !eth_en || (mem_req && $stable(mem_addr) && $stable(mem_we)));

  p_beat_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready && eth_en |=>
      !eth_en || (tx_valid && $stable(tx_data) && $stable(tx_last)));

  p_wb_clears_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> !mem_wdata[31]);

  p_babble_on_buf_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_babble |-> ev_buf);

  p_events_apart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_buf, ev_frame}));

  p_quiet_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !eth_en |=> !mem_req && !tx_valid);
endmodule

bind txr_ring_walker txr_ring_walker_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .eth_en(eth_en), .mem_req(mem_req),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_ack(mem_ack), .tx_data(tx_data), .tx_valid(tx_valid),
  .tx_last(tx_last), .tx_ready(tx_ready), .ev_buf(ev_buf),
  .ev_frame(ev_frame), .ev_babble(ev_babble)
);

// File: tb/txr_ring_walker_tb_top.sv
module txr_ring_walker_tb_top;
  localparam int MAXF = 48;
  localparam logic [15:0] RDY = 16'h8000, WRP = 16'h2000, LST = 16'h0800;

  logic clk = 1'b0, rst_n = 1'b0;
  logic eth_en = 1'b0, kick = 1'b0;
  logic [31:0] ring_base = 32'h0;
  logic mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = 32'h0;
  logic [7:0] tx_data;
  logic tx_valid, tx_last, tx_ready = 1'b0;
  logic ev_buf, ev_frame, ev_babble;

  always #2.5 clk = ~clk;

  txr_ring_walker #(.AW(32), .MAX_FRAME(MAXF)) dut_i (
    .clk(clk), .rst_n(rst_n), .eth_en(eth_en), .kick(kick),
    .ring_base(ring_base), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_last(tx_last), .tx_ready(tx_ready), .ev_buf(ev_buf),
    .ev_frame(ev_frame), .ev_babble(ev_babble)
  );

  logic [7:0] mem [0:4095];
  logic [7:0] cap [0:255];
  logic [7:0] expb [0:255];
  int cap_len, exp_len, n_last, n_buf, n_frm, n_bab, n_req;
  int errs = 0, nchk = 0, cyc = 0, wcnt = 0, lat = 0;
  logic seen_req;
  logic [31:0] first_addr;

  function automatic logic [7:0] pat(int a);
    return 8'((a * 13) + (a >> 8) + 5);
  endfunction

  function automatic logic [31:0] rd32(int a);
    int b = a & 32'hFFC;
    return {mem[b+3], mem[b+2], mem[b+1], mem[b]};
  endfunction

  task automatic wr32(int a, logic [31:0] v);
    for (int k = 0; k < 4; k++) mem[(a & 32'hFFC) + k] = v[8*k +: 8];
  endtask

  task automatic set_desc(int a, logic [15:0] len, logic [15:0] flg, int b);
    wr32(a, {flg, len});
    wr32(a + 4, b);
  endtask

  task automatic add_exp(int b, int len);
    for (int i = 0; i < len; i++)
      if (exp_len < MAXF) begin expb[exp_len] = pat(b + i); exp_len++; end
  endtask

  task automatic chk(bit ok, string req, int act, int expv);
    nchk++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic clear_obs();
    cap_len = 0; exp_len = 0; n_last = 0; n_buf = 0; n_frm = 0;
    n_bab = 0; n_req = 0; seen_req = 1'b0; first_addr = '0;
  endtask

  task automatic wait_idle();
    int q = 0;
    repeat (3) @(negedge clk);
    for (int t = 0; t < 20000 && q < 8; t++) begin
      @(negedge clk);
      if (!mem_req && !tx_valid) q++; else q = 0;
    end
  endtask

  task automatic do_kick();
    @(negedge clk) kick = 1'b1;
    @(negedge clk) kick = 1'b0;
    wait_idle();
  endtask

  task automatic chk_frame(string req);
    bit same = (cap_len == exp_len);
    chk(cap_len == exp_len, req, cap_len, exp_len);
    for (int i = 0; i < exp_len && same; i++)
      if (cap[i] !== expb[i]) begin
        same = 0;
        chk(0, req, cap[i], expb[i]);
      end
    if (same) chk(1, req, 0, 0);
    chk(n_last == 1, req, n_last, 1);
  endtask

  // Memory responder and stream sink, evaluated at the falling edge.
  always @(negedge clk) begin
    cyc++;
    tx_ready = (cyc % 3) != 0;
    if (tx_valid && tx_ready) begin
      cap[cap_len[7:0]] = tx_data;
      cap_len++;
      if (tx_last) n_last++;
    end
    if (ev_buf) n_buf++;
    if (ev_frame) n_frm++;
    if (ev_babble) n_bab++;
    if (mem_req) begin
      if (!seen_req) begin seen_req = 1'b1; first_addr = mem_addr; end
      if (wcnt >= lat) begin
        mem_ack = 1'b1;
        if (mem_we) wr32(int'(mem_addr), mem_wdata);
        else mem_rdata = rd32(int'(mem_addr));
        wcnt = 0; lat = (lat + 1) % 3; n_req++;
      end else begin
        mem_ack = 1'b0; wcnt++;
      end
    end else begin
      mem_ack = 1'b0; wcnt = 0;
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      errs++; nchk++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("Result: errors=%0d of %0d checks", errs, nchk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = pat(i);
    for (int a = 32'h100; a < 32'h220; a++) mem[a] = 8'h00;
    clear_obs();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!mem_req && !tx_valid, "R1 idle outputs", {mem_req, tx_valid}, 0);
    chk(!ev_buf && !ev_frame && !ev_babble, "R1 events", {ev_buf, ev_frame, ev_babble}, 0);
    rst_n = 1'b1;
    ring_base = 32'h100;
    repeat (3) @(negedge clk);

    // R9: kick with enable low is dropped, not remembered
    set_desc(32'h100, 16'd5, RDY, 32'h401);
    set_desc(32'h108, 16'd3, RDY | LST, 32'h480);
    clear_obs();
    do_kick();
    chk(n_req == 0, "R9 no request while disabled", n_req, 0);
    @(negedge clk) eth_en = 1'b1;
    repeat (20) @(negedge clk);
    chk(n_req == 0, "R9 kick not remembered", n_req, 0);

    // R2 R5 R7 R8 R3: two-buffer frame, stop at empty descriptor
    clear_obs();
    add_exp(32'h401, 5); add_exp(32'h480, 3);
    do_kick();
    chk_frame("R5 two-buffer frame");
    chk(first_addr == 32'h100, "R2 first read at pointer", first_addr, 32'h100);
    chk(n_buf == 2, "R7 buffer events", n_buf, 2);
    chk(n_frm == 1, "R7 frame events", n_frm, 1);
    chk(n_bab == 0, "R6 no babble", n_bab, 0);
    chk(rd32(32'h100) == 32'h0000_0005, "R8 writeback d0", rd32(32'h100), 32'h5);
    chk(rd32(32'h108) == {LST, 16'd3}, "R8 writeback d1", rd32(32'h108), {LST, 16'd3});
    chk(rd32(32'h110) == 0, "R3 stop descriptor untouched", rd32(32'h110), 0);

    // R3 R4: resume at stop point, wrap back to base
    set_desc(32'h110, 16'd4, RDY | LST | WRP, 32'h4A3);
    clear_obs(); add_exp(32'h4A3, 4);
    do_kick();
    chk_frame("R3 resume at stop pointer");
    chk(first_addr == 32'h110, "R3 resume address", first_addr, 32'h110);
    set_desc(32'h100, 16'd2, RDY | LST, 32'h4C0);
    clear_obs(); add_exp(32'h4C0, 2);
    do_kick();
    chk_frame("R4 wrap to ring base");
    chk(first_addr == 32'h100, "R4 wrap address", first_addr, 32'h100);

    // R6: truncation at MAXF
    set_desc(32'h108, 16'd40, RDY, 32'h500);
    set_desc(32'h110, 16'd20, RDY | LST | WRP, 32'h540);
    clear_obs(); add_exp(32'h500, 40); add_exp(32'h540, 20);
    do_kick();
    chk_frame("R6 truncated frame");
    chk(n_bab == 1, "R6 babble count", n_bab, 1);
    chk(n_buf == 2, "R7 buffer events trunc", n_buf, 2);
    chk(rd32(32'h110) == {LST | WRP, 16'd20}, "R8 length kept", rd32(32'h110), {LST | WRP, 16'd20});

    // R10: disable reloads pointer from new base
    @(negedge clk) eth_en = 1'b0;
    ring_base = 32'h200;
    repeat (2) @(negedge clk);
    eth_en = 1'b1;
    set_desc(32'h200, 16'd3, RDY | LST | WRP, 32'h5F1);
    clear_obs(); add_exp(32'h5F1, 3);
    do_kick();
    chk(first_addr == 32'h200, "R10 reload from base", first_addr, 32'h200);
    chk_frame("R10 frame after reload");

    // R5 R4 R7 R8: sweep over buffer lengths and lane offsets
    for (int la = 0; la < 5; la++)
      for (int lb = 1; lb < 5; lb++) begin
        set_desc(32'h200, 16'(la), RDY, 32'h600 + la);
        set_desc(32'h208, 16'(lb), RDY | LST | WRP, 32'h700 + 3 * lb);
        clear_obs(); add_exp(32'h600 + la, la); add_exp(32'h700 + 3 * lb, lb);
        do_kick();
        chk_frame("R5 sweep frame");
        chk(n_buf == 2 && n_frm == 1, "R7 sweep events", n_buf * 16 + n_frm, 33);
        chk(rd32(32'h200) == la, "R8 sweep writeback", rd32(32'h200), la);
        chk(first_addr == 32'h200, "R4 sweep wrap", first_addr, 32'h200);
      end

    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end
endmodule